// File: doc/BRIEF.md
# Sixteen-Bit Instruction Decoder

This block turns one 16-bit instruction word into everything the execution datapath needs for that instruction in the same cycle. It is purely combinational. A 3-bit opcode at bits 8:6 selects one of four layouts: two register-immediate layouts, a three-register layout with a signedness bit, and a branch layout whose operation is chosen by a 2-bit function code in bits 1:0. From the layout the decoder extracts register indices for the 8-entry main register file, a 2-bit index into the 4-entry bank file, a shift amount, a signedness flag and up to two immediates. Each immediate is sign- or zero-extended to 16 bits as its operation requires.

The decoder also drives the control strobes: main register-file write, memory write, memory read and bank-file write. It also gives an ALU operation code and a next-PC source. An opcode or function code with no meaning raises an illegal flag and holds every strobe low. Register files, memory, the ALU and the PC adder are outside the block.

Top module: `instr_dec16`

## Requirements
- R1: `op_o` is taken from opcode bits 8:6: 000 gives 0 (store-immediate), 001 gives 1 (compare-immediate), 010 gives 2 (load-shifted), 011 gives 3 (upper-immediate shift), 100 gives 4 (subtract-shift) and 110 gives 5 (merge/branch).
- R2: With opcode 111, function bits 1:0 = 01 give `op_o` = 6 (compare-and-branch through the bank) and 10 give `op_o` = 7 (relative jump-and-link).
- R3: Opcode 101, and opcode 111 with function 00 or 11, set `illegal_o`, give `op_o` = 15, drive all four strobes low, and give ALU code 0 and PC source 0.
- R4: For opcodes 000 and 001, `rd_o` = bits 15:13, `rs_o` = bits 5:3 and `rt_o` = bits 2:0. The 4-bit immediate in bits 12:9 is zero-extended for op 0 and sign-extended for op 1.
- R5: For opcodes 010 and 011, `rd_o` = bits 2:0 and `shamt_o` = bits 5:3. Op 2 gives `imm_o` = sign-extension of {bits 15:9, 4'b0000}. Op 3 gives `imm_o` = sign-extension of bits 15:9.
- R6: For opcodes 100 and 110, `rs_o` = bits 15:13, `signed_o` = bit 12, `rd_o` = bits 11:9, `rt_o` = bits 5:3 and `shamt_o` = bits 2:0.
- R7: For op 6 and op 7, `bank_addr_o` = bits 10:9. Op 6 gives `imm_o` = sign-extension of bits 5:2 and `imm2_o` = sign-extension of bits 15:11. Op 7 gives `imm_o` = zero-extension of {bits 15:11, bits 5:2} and `imm2_o` = 0.
- R8: Strobes are set per op and all others are 0. Op 0 sets mem write. Op 2 sets mem read and rf write. Ops 1, 3, 4 and 5 set rf write. Ops 6 and 7 set bank write.
- R9: `alu_op_o` is 1 (add) for op 0, 2 (equality) for op 1, 3 (pass) for op 2, 4 (upper shift) for op 3 and 5 (subtract) for op 4. It is 6 (merge) for op 5 with bit 12 = 1, 7 (invert) for op 5 with bit 12 = 0, and 8 (less-than) for op 6. Op 7 gives 1 (add).
- R10: `pc_sel_o` is 1 (bank target if less) for op 6 and 2 (relative) for op 7. For op 5 it is 3 (add) when bit 12 = 1 and 4 (shift) when bit 12 = 0. Every other case gives 0 (increment).
- R11: Fields that the current layout does not carry read as 0. This covers register indices, shift amount, bank index, signedness flag and both immediates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| op_o | output | 4 | Decoded operation code |
| illegal_o | output | 1 | Undefined opcode or function code |
| rd_o | output | 3 | Destination register index |
| rs_o | output | 3 | First source register index |
| rt_o | output | 3 | Second source register index |
| shamt_o | output | 3 | Shift amount |
| bank_addr_o | output | 2 | Bank file index |
| signed_o | output | 1 | Signed variant select |
| imm_o | output | 16 | Primary extended immediate |
| imm2_o | output | 16 | Secondary extended immediate |
| rf_we_o | output | 1 | Main register-file write |
| mem_we_o | output | 1 | Memory write |
| mem_re_o | output | 1 | Memory read |
| bank_we_o | output | 1 | Bank file write |
| alu_op_o | output | 4 | ALU operation code |
| pc_sel_o | output | 3 | Next-PC source |

## Verification
The immediates use patterns whose top bit is set. A decoder that swaps sign and zero extension, or that drops the four zero bits appended for the load-shifted case, then gives a wrong upper byte. The three undefined codes are driven with every other bit set to 1, so a strobe that leaks through or a field that is not cleared becomes visible. Bit 12 is toggled under opcode 110 to catch a decoder that ignores it when choosing the ALU code and the PC source. Register fields get distinct values so that a slice taken from the wrong layout shows up as a wrong index.

// File: rtl/zq_dec_pkg.sv
package zq_dec_pkg;

   localparam int unsigned WORD_W = 16;

   typedef enum logic [3:0] {
      OP_STOI    = 4'd0,
      OP_CMPI    = 4'd1,
      OP_LTOR    = 4'd2,
      OP_LUIS    = 4'd3,
      OP_SUBS    = 4'd4,
      OP_BEON    = 4'd5,
      OP_BGTI    = 4'd6,
      OP_JALV    = 4'd7,
      OP_ILLEGAL = 4'd15
   } op_e;

   typedef enum logic [2:0] {
      FMT_Z    = 3'd0,
      FMT_I    = 3'd1,
      FMT_Q    = 3'd2,
      FMT_N    = 3'd3,
      FMT_NONE = 3'd4
   } fmt_e;

   typedef enum logic [3:0] {
      ALU_NONE  = 4'd0,
      ALU_ADD   = 4'd1,
      ALU_EQ    = 4'd2,
      ALU_PASS  = 4'd3,
      ALU_UPPER = 4'd4,
      ALU_SUB   = 4'd5,
      ALU_MERGE = 4'd6,
      ALU_INV   = 4'd7,
      ALU_LT    = 4'd8
   } alu_e;

   typedef enum logic [2:0] {
      PC_INC     = 3'd0,
      PC_BANK_LT = 3'd1,
      PC_REL     = 3'd2,
      PC_ADD     = 3'd3,
      PC_SHIFT   = 3'd4
   } pcsel_e;

endpackage

// File: rtl/instr_dec_opclass.sv
module instr_dec_opclass
   import zq_dec_pkg::*;
(
   input  logic [2:0] opc_i,
   input  logic [1:0] funct_i,
   output op_e        op_o,
   output fmt_e       fmt_o,
   output logic       illegal_o
);

   always_comb begin
      op_o      = OP_ILLEGAL;
      fmt_o     = FMT_NONE;
      unique case (opc_i)
         3'b000: begin op_o = OP_STOI; fmt_o = FMT_Z; end
         3'b001: begin op_o = OP_CMPI; fmt_o = FMT_Z; end
         3'b010: begin op_o = OP_LTOR; fmt_o = FMT_I; end
         3'b011: begin op_o = OP_LUIS; fmt_o = FMT_I; end
         3'b100: begin op_o = OP_SUBS; fmt_o = FMT_Q; end
         3'b110: begin op_o = OP_BEON; fmt_o = FMT_Q; end
         3'b111: begin
            if (funct_i == 2'b01) begin
               op_o  = OP_BGTI;
               fmt_o = FMT_N;
            end else if (funct_i == 2'b10) begin
               op_o  = OP_JALV;
               fmt_o = FMT_N;
            end
         end
         default: ;
      endcase
      illegal_o = (fmt_o == FMT_NONE);
   end

endmodule

// File: rtl/instr_dec_fields.sv
module instr_dec_fields
   import zq_dec_pkg::*;
#(
   parameter int unsigned INSTR_W       = 16,
   parameter int unsigned REG_IDX_W     = 3,
   parameter int unsigned BANK_IDX_W    = 2,
   parameter int unsigned SHAMT_W       = 3,
   parameter int unsigned IMM_OUT_W     = 16,
   parameter bit          JALV_PRESHIFT = 1'b0
) (
   input  logic [INSTR_W-1:0]    instr_i,
   input  op_e                   op_i,
   input  fmt_e                  fmt_i,
   output logic [REG_IDX_W-1:0]  rd_o,
   output logic [REG_IDX_W-1:0]  rs_o,
   output logic [REG_IDX_W-1:0]  rt_o,
   output logic [SHAMT_W-1:0]    shamt_o,
   output logic [BANK_IDX_W-1:0] bank_addr_o,
   output logic                  signed_o,
   output logic [IMM_OUT_W-1:0]  imm_o,
   output logic [IMM_OUT_W-1:0]  imm2_o
);

   localparam int unsigned Z_IMM_W  = 4;
   localparam int unsigned I_IMM_W  = 7;
   localparam int unsigned I_PAD_W  = 4;
   localparam int unsigned I_LD_W   = I_IMM_W + I_PAD_W;
   localparam int unsigned N_HI_W   = 5;
   localparam int unsigned N_LO_W   = 4;
   localparam int unsigned N_JAL_W  = N_HI_W + N_LO_W;

   logic [Z_IMM_W-1:0] z_imm;
   logic [I_IMM_W-1:0] i_imm;
   logic [I_LD_W-1:0]  i_ld;
   logic [N_HI_W-1:0]  n_hi;
   logic [N_LO_W-1:0]  n_lo;
   logic [N_JAL_W-1:0] n_jal;

   assign z_imm = instr_i[12:9];
   assign i_imm = instr_i[15:9];
   assign i_ld  = {i_imm, {I_PAD_W{1'b0}}};
   assign n_hi  = instr_i[15:11];
   assign n_lo  = instr_i[5:2];
   assign n_jal = {n_hi, n_lo};

   logic [IMM_OUT_W-1:0] z_imm_zx, z_imm_sx, i_ld_sx, i_imm_sx;
   logic [IMM_OUT_W-1:0] n_lo_sx, n_hi_sx, n_jal_off;

   assign z_imm_zx = {{(IMM_OUT_W-Z_IMM_W){1'b0}}, z_imm};
   assign z_imm_sx = {{(IMM_OUT_W-Z_IMM_W){z_imm[Z_IMM_W-1]}}, z_imm};
   assign i_ld_sx  = {{(IMM_OUT_W-I_LD_W){i_ld[I_LD_W-1]}}, i_ld};
   assign i_imm_sx = {{(IMM_OUT_W-I_IMM_W){i_imm[I_IMM_W-1]}}, i_imm};
   assign n_lo_sx  = {{(IMM_OUT_W-N_LO_W){n_lo[N_LO_W-1]}}, n_lo};
   assign n_hi_sx  = {{(IMM_OUT_W-N_HI_W){n_hi[N_HI_W-1]}}, n_hi};

   generate
      if (JALV_PRESHIFT) begin : g_jal_shifted
         assign n_jal_off = {{(IMM_OUT_W-N_JAL_W-1){1'b0}}, n_jal, 1'b0};
      end else begin : g_jal_plain
         assign n_jal_off = {{(IMM_OUT_W-N_JAL_W){1'b0}}, n_jal};
      end
   endgenerate

   always_comb begin
      rd_o        = '0;
      rs_o        = '0;
      rt_o        = '0;
      shamt_o     = '0;
      bank_addr_o = '0;
      signed_o    = 1'b0;
      imm_o       = '0;
      imm2_o      = '0;
      unique case (fmt_i)
         FMT_Z: begin
            rd_o  = instr_i[15:13];
            rs_o  = instr_i[5:3];
            rt_o  = instr_i[2:0];
            imm_o = (op_i == OP_STOI) ? z_imm_zx : z_imm_sx;
         end
         FMT_I: begin
            rd_o    = instr_i[2:0];
            shamt_o = instr_i[5:3];
            imm_o   = (op_i == OP_LTOR) ? i_ld_sx : i_imm_sx;
         end
         FMT_Q: begin
            rs_o     = instr_i[15:13];
            signed_o = instr_i[12];
            rd_o     = instr_i[11:9];
            rt_o     = instr_i[5:3];
            shamt_o  = instr_i[2:0];
         end
         FMT_N: begin
            bank_addr_o = instr_i[10:9];
            if (op_i == OP_BGTI) begin
               imm_o  = n_lo_sx;
               imm2_o = n_hi_sx;
            end else begin
               imm_o  = n_jal_off;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/instr_dec_ctrl.sv
module instr_dec_ctrl
   import zq_dec_pkg::*;
(
   input  op_e    op_i,
   input  logic   qbit_i,
   output logic   rf_we_o,
   output logic   mem_we_o,
   output logic   mem_re_o,
   output logic   bank_we_o,
   output alu_e   alu_op_o,
   output pcsel_e pc_sel_o
);

   always_comb begin
      rf_we_o   = 1'b0;
      mem_we_o  = 1'b0;
      mem_re_o  = 1'b0;
      bank_we_o = 1'b0;
      alu_op_o  = ALU_NONE;
      pc_sel_o  = PC_INC;
      unique case (op_i)
         OP_STOI: begin mem_we_o = 1'b1; alu_op_o = ALU_ADD; end
         OP_CMPI: begin rf_we_o = 1'b1; alu_op_o = ALU_EQ; end
         OP_LTOR: begin
            rf_we_o  = 1'b1;
            mem_re_o = 1'b1;
            alu_op_o = ALU_PASS;
         end
         OP_LUIS: begin rf_we_o = 1'b1; alu_op_o = ALU_UPPER; end
         OP_SUBS: begin rf_we_o = 1'b1; alu_op_o = ALU_SUB; end
         OP_BEON: begin
            rf_we_o  = 1'b1;
            alu_op_o = qbit_i ? ALU_MERGE : ALU_INV;
            pc_sel_o = qbit_i ? PC_ADD : PC_SHIFT;
         end
         OP_BGTI: begin
            bank_we_o = 1'b1;
            alu_op_o  = ALU_LT;
            pc_sel_o  = PC_BANK_LT;
         end
         OP_JALV: begin
            bank_we_o = 1'b1;
            alu_op_o  = ALU_ADD;
            pc_sel_o  = PC_REL;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/instr_dec16.sv
module instr_dec16
   import zq_dec_pkg::*;
#(
   parameter int unsigned INSTR_W       = 16,
   parameter int unsigned REG_IDX_W     = 3,
   parameter int unsigned BANK_IDX_W    = 2,
   parameter int unsigned SHAMT_W       = 3,
   parameter int unsigned IMM_OUT_W     = 16,
   parameter bit          JALV_PRESHIFT = 1'b0
) (
   input  logic [INSTR_W-1:0]    instr_i,
   output logic [3:0]            op_o,
   output logic                  illegal_o,
   output logic [REG_IDX_W-1:0]  rd_o,
   output logic [REG_IDX_W-1:0]  rs_o,
   output logic [REG_IDX_W-1:0]  rt_o,
   output logic [SHAMT_W-1:0]    shamt_o,
   output logic [BANK_IDX_W-1:0] bank_addr_o,
   output logic                  signed_o,
   output logic [IMM_OUT_W-1:0]  imm_o,
   output logic [IMM_OUT_W-1:0]  imm2_o,
   output logic                  rf_we_o,
   output logic                  mem_we_o,
   output logic                  mem_re_o,
   output logic                  bank_we_o,
   output logic [3:0]            alu_op_o,
   output logic [2:0]            pc_sel_o
);

   localparam int unsigned OPC_LSB = 6;
   localparam int unsigned OPC_W   = 3;
   localparam int unsigned FN_W    = 2;
   localparam int unsigned Q_BIT   = 12;

   generate
      if (INSTR_W != WORD_W) begin : g_bad_word
         $error("instr_dec16: INSTR_W must be 16");
      end
      if (REG_IDX_W != 3) begin : g_bad_reg
         $error("instr_dec16: REG_IDX_W must be 3");
      end
      if (BANK_IDX_W != 2) begin : g_bad_bank
         $error("instr_dec16: BANK_IDX_W must be 2");
      end
      if (SHAMT_W != 3) begin : g_bad_shamt
         $error("instr_dec16: SHAMT_W must be 3");
      end
      if (IMM_OUT_W < 11) begin : g_bad_imm
         $error("instr_dec16: IMM_OUT_W too narrow");
      end
   endgenerate

   op_e    op;
   fmt_e   fmt;
   alu_e   alu_op;
   pcsel_e pc_sel;

   instr_dec_opclass i_opclass (
      .opc_i     (instr_i[OPC_LSB +: OPC_W]),
      .funct_i   (instr_i[FN_W-1:0]),
      .op_o      (op),
      .fmt_o     (fmt),
      .illegal_o (illegal_o)
   );

   instr_dec_fields #(
      .INSTR_W       (INSTR_W),
      .REG_IDX_W     (REG_IDX_W),
      .BANK_IDX_W    (BANK_IDX_W),
      .SHAMT_W       (SHAMT_W),
      .IMM_OUT_W     (IMM_OUT_W),
      .JALV_PRESHIFT (JALV_PRESHIFT)
   ) i_fields (
      .instr_i     (instr_i),
      .op_i        (op),
      .fmt_i       (fmt),
      .rd_o        (rd_o),
      .rs_o        (rs_o),
      .rt_o        (rt_o),
      .shamt_o     (shamt_o),
      .bank_addr_o (bank_addr_o),
      .signed_o    (signed_o),
      .imm_o       (imm_o),
      .imm2_o      (imm2_o)
   );

   instr_dec_ctrl i_ctrl (
      .op_i      (op),
      .qbit_i    (instr_i[Q_BIT]),
      .rf_we_o   (rf_we_o),
      .mem_we_o  (mem_we_o),
      .mem_re_o  (mem_re_o),
      .bank_we_o (bank_we_o),
      .alu_op_o  (alu_op),
      .pc_sel_o  (pc_sel)
   );

   assign op_o     = op;
   assign alu_op_o = alu_op;
   assign pc_sel_o = pc_sel;

endmodule

// File: rtl/instr_dec16_chk.sv
module instr_dec16_chk (
   input logic [15:0] instr_i,
   input logic [3:0]  op_o,
   input logic        illegal_o,
   input logic        signed_o,
   input logic [15:0] imm2_o,
   input logic        rf_we_o,
   input logic        mem_we_o,
   input logic        mem_re_o,
   input logic        bank_we_o,
   input logic [2:0]  pc_sel_o
);

   always_comb begin
      if (!$isunknown(instr_i)) begin
         // R3: an undefined code never lets a strobe through
         a_r3_illegal_quiet: assert (!illegal_o ||
            (!rf_we_o && !mem_we_o && !mem_re_o && !bank_we_o && pc_sel_o == 3'd0))
            else $error("illegal word drove a strobe");
         // R3: the flag and the illegal op code agree
         a_r3_flag_matches_op: assert (illegal_o == (op_o == 4'd15))
            else $error("illegal flag disagrees with op code");
         // R8: at most one storage target per instruction
         a_r8_one_target: assert ($onehot0({rf_we_o, mem_we_o, bank_we_o}))
            else $error("more than one write target");
         // R8: a memory read always lands in the register file
         a_r8_read_to_rf: assert (!mem_re_o || rf_we_o)
            else $error("memory read without register write");
         // R6: the signedness flag only comes from the three-register layout
         a_r6_signed_from_q: assert (!signed_o || op_o == 4'd4 || op_o == 4'd5)
            else $error("signed flag outside three-register ops");
         // R7: bank writes only for the branch layout
         a_r7_bank_from_n: assert (!bank_we_o || instr_i[8:6] == 3'b111)
            else $error("bank write outside opcode 111");
         // R11: the second immediate exists only for op 6
         a_r11_imm2_only_bgti: assert (imm2_o == 16'h0 || op_o == 4'd6)
            else $error("second immediate outside op 6");
         // R10: a non-sequential PC only for branch-type ops
         a_r10_pc_only_branch: assert (pc_sel_o == 3'd0 || op_o == 4'd5 ||
                                       op_o == 4'd6 || op_o == 4'd7)
            else $error("PC source set on a non-branch op");
      end
   end

endmodule

bind instr_dec16 instr_dec16_chk i_instr_dec16_chk (
   .instr_i   (instr_i),
   .op_o      (op_o),
   .illegal_o (illegal_o),
   .signed_o  (signed_o),
   .imm2_o    (imm2_o),
   .rf_we_o   (rf_we_o),
   .mem_we_o  (mem_we_o),
   .mem_re_o  (mem_re_o),
   .bank_we_o (bank_we_o),
   .pc_sel_o  (pc_sel_o)
);

// File: tb/test_instr_dec16.sv
module test_instr_dec16;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr;
   logic [3:0]  op;
   logic        illegal;
   logic [2:0]  rd, rs, rt, shamt;
   logic [1:0]  bank_addr;
   logic        sgn;
   logic [15:0] imm, imm2;
   logic        rf_we, mem_we, mem_re, bank_we;
   logic [3:0]  alu_op;
   logic [2:0]  pc_sel;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   instr_dec16 i_instr_dec16 (
      .instr_i     (instr),
      .op_o        (op),
      .illegal_o   (illegal),
      .rd_o        (rd),
      .rs_o        (rs),
      .rt_o        (rt),
      .shamt_o     (shamt),
      .bank_addr_o (bank_addr),
      .signed_o    (sgn),
      .imm_o       (imm),
      .imm2_o      (imm2),
      .rf_we_o     (rf_we),
      .mem_we_o    (mem_we),
      .mem_re_o    (mem_re),
      .bank_we_o   (bank_we),
      .alu_op_o    (alu_op),
      .pc_sel_o    (pc_sel)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] w);
      @(negedge clk);
      instr = w;
      #(CLK_PERIOD/4);
   endtask

   function automatic logic [15:0] mk_z(input logic [2:0] d, input logic [3:0] im,
                                        input logic [2:0] opc, input logic [2:0] s,
                                        input logic [2:0] t);
      return {d, im, opc, s, t};
   endfunction

   function automatic logic [15:0] mk_i(input logic [6:0] im, input logic [2:0] opc,
                                        input logic [2:0] sh, input logic [2:0] d);
      return {im, opc, sh, d};
   endfunction

   function automatic logic [15:0] mk_q(input logic [2:0] s, input logic q,
                                        input logic [2:0] d, input logic [2:0] opc,
                                        input logic [2:0] t, input logic [2:0] sh);
      return {s, q, d, opc, t, sh};
   endfunction

   function automatic logic [15:0] mk_n(input logic [4:0] hi, input logic [1:0] ba,
                                        input logic [3:0] lo, input logic [1:0] fn);
      return {hi, ba, 3'b111, lo, fn};
   endfunction

   task automatic strobes(input string req, input int rw, input int mw,
                          input int mr, input int bw);
      chk(req, "rf_we", rf_we, rw);
      chk(req, "mem_we", mem_we, mw);
      chk(req, "mem_re", mem_re, mr);
      chk(req, "bank_we", bank_we, bw);
   endtask

   task automatic t_reset_word;
      apply(16'h0000);
      chk("R1", "op zero word", op, 0);
      chk("R3", "illegal zero word", illegal, 0);
      chk("R4", "imm zero word", imm, 0);
      chk("R11", "shamt zero word", shamt, 0);
   endtask

   task automatic t_z_format;
      apply(mk_z(3'd5, 4'hA, 3'b000, 3'd3, 3'd6));
      chk("R1", "op stoi", op, 0);
      chk("R4", "rd", rd, 5);
      chk("R4", "rs", rs, 3);
      chk("R4", "rt", rt, 6);
      chk("R4", "imm zero-ext", imm, 16'h000A);
      strobes("R8", 0, 1, 0, 0);
      chk("R9", "alu stoi", alu_op, 1);
      chk("R10", "pc stoi", pc_sel, 0);
      chk("R11", "bank stoi", bank_addr, 0);
      chk("R11", "signed stoi", sgn, 0);
      chk("R11", "imm2 stoi", imm2, 0);
      apply(mk_z(3'd2, 4'hA, 3'b001, 3'd7, 3'd1));
      chk("R1", "op cmpi", op, 1);
      chk("R4", "imm sign-ext", imm, 16'hFFFA);
      chk("R4", "rd cmpi", rd, 2);
      strobes("R8", 1, 0, 0, 0);
      chk("R9", "alu cmpi", alu_op, 2);
      apply(mk_z(3'd2, 4'h5, 3'b001, 3'd7, 3'd1));
      chk("R4", "imm positive", imm, 16'h0005);
   endtask

   task automatic t_i_format;
      apply(mk_i(7'h41, 3'b010, 3'd6, 3'd4));
      chk("R1", "op ltor", op, 2);
      chk("R5", "imm ltor neg", imm, 16'hFC10);
      chk("R5", "shamt", shamt, 6);
      chk("R5", "rd", rd, 4);
      strobes("R8", 1, 0, 1, 0);
      chk("R9", "alu ltor", alu_op, 3);
      chk("R11", "rs ltor", rs, 0);
      apply(mk_i(7'h15, 3'b010, 3'd1, 3'd7));
      chk("R5", "imm ltor pos", imm, 16'h0150);
      apply(mk_i(7'h41, 3'b011, 3'd2, 3'd3));
      chk("R1", "op luis", op, 3);
      chk("R5", "imm luis neg", imm, 16'hFFC1);
      strobes("R8", 1, 0, 0, 0);
      chk("R9", "alu luis", alu_op, 4);
      apply(mk_i(7'h15, 3'b011, 3'd2, 3'd3));
      chk("R5", "imm luis pos", imm, 16'h0015);
   endtask

   task automatic t_q_format;
      apply(mk_q(3'd2, 1'b1, 3'd7, 3'b100, 3'd4, 3'd5));
      chk("R1", "op subs", op, 4);
      chk("R6", "rs", rs, 2);
      chk("R6", "signed", sgn, 1);
      chk("R6", "rd", rd, 7);
      chk("R6", "rt", rt, 4);
      chk("R6", "shamt", shamt, 5);
      chk("R9", "alu subs", alu_op, 5);
      chk("R11", "imm subs", imm, 0);
      apply(mk_q(3'd6, 1'b0, 3'd1, 3'b110, 3'd3, 3'd2));
      chk("R1", "op beon", op, 5);
      chk("R6", "unsigned", sgn, 0);
      chk("R9", "alu beon q0", alu_op, 7);
      chk("R10", "pc beon q0", pc_sel, 4);
      strobes("R8", 1, 0, 0, 0);
      apply(mk_q(3'd6, 1'b1, 3'd1, 3'b110, 3'd3, 3'd2));
      chk("R9", "alu beon q1", alu_op, 6);
      chk("R10", "pc beon q1", pc_sel, 3);
   endtask

   task automatic t_n_format;
      apply(mk_n(5'b10011, 2'd2, 4'b0110, 2'b01));
      chk("R2", "op bgti", op, 6);
      chk("R7", "bank addr", bank_addr, 2);
      chk("R7", "imm low", imm, 16'h0006);
      chk("R7", "imm high", imm2, 16'hFFF3);
      strobes("R8", 0, 0, 0, 1);
      chk("R9", "alu bgti", alu_op, 8);
      chk("R10", "pc bgti", pc_sel, 1);
      chk("R11", "rd bgti", rd, 0);
      apply(mk_n(5'b10011, 2'd1, 4'b1110, 2'b10));
      chk("R2", "op jalv", op, 7);
      chk("R7", "bank addr jalv", bank_addr, 1);
      chk("R7", "imm jalv", imm, 16'h013E);
      chk("R7", "imm2 jalv", imm2, 0);
      chk("R9", "alu jalv", alu_op, 1);
      chk("R10", "pc jalv", pc_sel, 2);
      strobes("R8", 0, 0, 0, 1);
   endtask

   task automatic t_illegal;
      logic [15:0] words [3];
      words[0] = 16'hFF7F;  // opcode 101, all else ones
      words[1] = 16'hFFFC;  // opcode 111, function 00
      words[2] = 16'hFFFF;  // opcode 111, function 11
      for (int k = 0; k < 3; k++) begin
         apply(words[k]);
         chk("R3", "illegal flag", illegal, 1);
         chk("R3", "op illegal", op, 15);
         strobes("R3", 0, 0, 0, 0);
         chk("R3", "alu illegal", alu_op, 0);
         chk("R3", "pc illegal", pc_sel, 0);
         chk("R11", "rd illegal", rd, 0);
         chk("R11", "imm illegal", imm, 0);
         chk("R11", "bank illegal", bank_addr, 0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      instr = 16'h0000;
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_reset_word();
      t_z_format();
      t_i_format();
      t_q_format();
      t_n_format();
      t_illegal();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule